// File: doc/BRIEF.md
# Framed Serial DAC Word Receiver

This block takes a DAC write from a three-wire serial link and turns it into one parallel code update. The link has an active-low frame select, a serial clock that idles high, and a data line. All three are sampled in a faster system clock domain. The system clock must run at least four times faster than the serial clock.

A frame starts when frame select goes low. Data is taken on each falling edge of the serial clock, most significant bit first. A frame is 24 bits long. The first 8 bits are control and padding bits and are dropped. The last 16 bits are the code.

On the 24th falling edge the block raises a one-cycle update strobe, and the new code appears on the code output in that same cycle. If frame select goes high before the 24th falling edge, the frame is cancelled and the code output keeps its old value.

The output is a valid-only stream and has no ready input. The serial link cannot be stalled, so no back-pressure is possible. The consumer must take the code in the cycle the strobe is high. The code output holds its value between updates.

Top module: `serdac_frame_rx`

## Requirements
- R1: A synchronous active-high reset clears the code output to 0x0000, drops the strobe, and returns the receiver to idle. This also applies when reset arrives in the middle of a frame.
- R2: A frame of 24 falling serial-clock edges, taken MSB first, puts bits 15:0 of the received word on the code output. Bits 23:16 have no effect on the output.
- R3: The update strobe is high for exactly one system-clock cycle per completed frame. The code output changes only in a cycle where the strobe is high.
- R4: If frame select goes high after fewer than 24 falling edges, the frame is cancelled. No strobe is produced and the code output keeps its previous value.
- R5: Falling serial-clock edges while frame select is high are ignored. They neither shift data nor advance the bit count.
- R6: After the 24th falling edge, further falling edges in the same frame are ignored. They cause no second strobe and no change to the code until frame select goes high and then low again.
- R7: Every new low period of frame select starts the bit count from zero. A full frame that follows a cancelled one decodes only its own 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n_i | input | 1 | Frame select, active low, asynchronous to clk |
| sclk_i | input | 1 | Serial clock, idles high, asynchronous to clk |
| sdata_i | input | 1 | Serial data, taken on falling sclk edges |
| upd_valid_o | output | 1 | One-cycle update strobe |
| upd_code_o | output | 16 | DAC code, held between updates |

## Verification
The hardest situations to reach are at the edges of the bit count:
- a frame cancelled after 23 edges, one short of the commit point;
- surplus serial-clock edges after a completed frame;
- edges clocked while frame select is high.

Random frames draw an edge count from 0 to 24 and, for full frames, add up to four surplus edges. Directed cases then force the 23-edge cancellation followed by a full frame, edges clocked while the frame is idle, and a reset in the middle of a frame. A bench model of the last committed code predicts the output after each frame and the number of strobes it should produce.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_DONE  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg_q[0] <= RST_VAL;
    else     stg_q[0] <= d_i;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg_q[g] <= RST_VAL;
        else     stg_q[g] <= stg_q[g-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/serdac_edge.sv
module serdac_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s_i,
  output logic sclk_fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sclk_s_i;
  end

  assign sclk_fall_o = prev_q & ~sclk_s_i;

  // a detected fall means the sampled clock is low next cycle, so no second fall
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sclk_fall_o |=> !sclk_fall_o); // R2
endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter
  import serdac_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_n_i,
  input  logic              fall_i,
  input  logic              din_i,
  output logic              commit_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  rx_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-2:0] sh_q;
  logic              last_bit;

  assign last_bit = (cnt_q == LAST);
  assign code_o   = {sh_q, din_i};
  assign commit_o = (st_q == RX_SHIFT) && !frm_n_i && fall_i && last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      case (st_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!frm_n_i) st_q <= RX_SHIFT;
        end
        RX_SHIFT: begin
          if (frm_n_i) begin
            st_q  <= RX_IDLE;
            cnt_q <= '0;
          end else if (fall_i) begin
            sh_q <= code_o[CODE_W-2:0];
            if (last_bit) begin
              st_q  <= RX_DONE;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        RX_DONE: begin
          if (frm_n_i) st_q <= RX_IDLE;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(WORD_W)); // R2
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (st_q == RX_IDLE) |-> (cnt_q == '0)); // R5
  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == RX_SHIFT && frm_n_i) |=> (st_q == RX_IDLE && cnt_q == '0)); // R4
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_q == RX_DONE && !frm_n_i) |=> (st_q == RX_DONE)); // R6
  AST_COMMIT_TO_DONE: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> (st_q == RX_DONE)); // R6
endmodule

// File: rtl/serdac_outreg.sv
module serdac_outreg #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o
);
  logic              valid_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      valid_q <= commit_i;
      if (commit_i) code_q <= code_i;
    end
  end

  assign valid_o = valid_q;
  assign code_o  = code_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q); // R3
  AST_CODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> $stable(code_q)); // R3
endmodule

// File: rtl/serdac_frame_rx.sv
module serdac_frame_rx #(
  parameter int WORD_W      = 24,
  parameter int CODE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic              upd_valid_o,
  output logic [CODE_W-1:0] upd_code_o
);
  logic [2:0]        raw, synced;
  logic              sclk_fall;
  logic              commit;
  logic [CODE_W-1:0] next_code;

  assign raw = {frame_n_i, sclk_i, sdata_i};

  serdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw),
    .q_o (synced)
  );

  serdac_edge u_edge (
    .clk         (clk),
    .rst         (rst),
    .sclk_s_i    (synced[1]),
    .sclk_fall_o (sclk_fall)
  );

  serdac_shifter #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .frm_n_i  (synced[2]),
    .fall_i   (sclk_fall),
    .din_i    (synced[0]),
    .commit_o (commit),
    .code_o   (next_code)
  );

  serdac_outreg #(.CODE_W(CODE_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .commit_i (commit),
    .code_i   (next_code),
    .valid_o  (upd_valid_o),
    .code_o   (upd_code_o)
  );

  AST_NO_STROBE_IDLE_FRAME: assert property (@(posedge clk) disable iff (rst)
    (synced[2] && $past(synced[2])) |=> !upd_valid_o); // R4
endmodule

// File: tb/serdac_frame_rx_test.sv
module serdac_frame_rx_test;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1;
  logic        sclk = 1'b1;
  logic        sdata = 1'b0;
  logic        upd_valid;
  logic [15:0] upd_code;

  int checks = 0;
  int errors = 0;
  int rises = 0;
  int hi_cycles = 0;
  int stray = 0;
  logic        prev_v = 1'b0;
  logic [15:0] prev_code = '0;
  logic [15:0] exp_code = '0;
  int cycles = 0;

  serdac_frame_rx uut (
    .clk         (clk),
    .rst         (rst),
    .frame_n_i   (frame_n),
    .sclk_i      (sclk),
    .sdata_i     (sdata),
    .upd_valid_o (upd_valid),
    .upd_code_o  (upd_code)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (upd_valid) hi_cycles++;
      if (upd_valid && !prev_v) rises++;
      if (!upd_valid && upd_code !== prev_code) stray++;
    end
    prev_v    = upd_valid;
    prev_code = upd_code;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clk(input logic b);
    sdata = b;
    wait_cyc(HALF);
    sclk = 1'b0;
    wait_cyc(HALF);
    sclk = 1'b1;
  endtask

  task automatic run_frame(input logic [23:0] w, input int nfall, input int extra);
    frame_n = 1'b0;
    wait_cyc(4);
    for (int i = 0; i < nfall; i++) pulse_clk(w[23-i]);
    for (int i = 0; i < extra; i++) pulse_clk(1'($urandom));
    wait_cyc(HALF);
    frame_n = 1'b1;
    wait_cyc(8);
  endtask

  // applies one frame and checks strobe count and code against the model
  task automatic frame_check(input logic [23:0] w, input int nfall, input int extra, input string req);
    int r0;
    r0 = rises;
    run_frame(w, nfall, extra);
    if (nfall >= 24) exp_code = w[15:0];
    check(rises - r0 == (nfall >= 24 ? 1 : 0), {req, " strobe count"},
          32'(rises - r0), (nfall >= 24) ? 32'd1 : 32'd0);
    check(upd_code === exp_code, {req, " code"}, 32'(upd_code), 32'(exp_code));
  endtask

  initial begin
    int r0;
    logic [23:0] w;
    int n;
    void'($urandom(32'h5EED_0D1C));

    // R1: reset state
    wait_cyc(5);
    check(upd_valid === 1'b0, "R1 strobe low in reset", 32'(upd_valid), 32'd0);
    check(upd_code === 16'h0, "R1 code zero in reset", 32'(upd_code), 32'd0);
    rst = 1'b0;
    wait_cyc(4);

    // R2: directed frames; upper byte must not leak into the code
    frame_check(24'hFF_A5C3, 24, 0, "R2 frame A5C3");
    frame_check(24'h00_5A3C, 24, 0, "R2 frame 5A3C");
    frame_check(24'hFF_0000, 24, 0, "R2 upper bits ignored");

    // R4: cancel after 23 edges, then R7: a fresh full frame
    frame_check(24'h00_FFFF, 23, 0, "R4 abort at 23");
    frame_check(24'h00_1234, 0, 0, "R4 empty frame");
    frame_check(24'h3C_8001, 24, 0, "R7 restart after abort");

    // R5: edges while idle must not count
    r0 = rises;
    for (int i = 0; i < 7; i++) pulse_clk(1'b1);
    wait_cyc(8);
    check(rises == r0, "R5 idle edges no strobe", 32'(rises - r0), 32'd0);
    frame_check(24'h81_7E55, 24, 0, "R5 frame after idle edges");

    // R6: surplus edges after a completed frame
    frame_check(24'h00_C001, 24, 5, "R6 surplus edges");

    // random mix of full, short and surplus frames
    for (int k = 0; k < 40; k++) begin
      w = 24'($urandom);
      n = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 23)) : 24;
      frame_check(w, n, (n == 24) ? int'($urandom_range(0, 4)) : 0,
                  (n == 24) ? "R2 random frame" : "R4 random abort");
    end

    // R1: reset mid-frame clears code and idles the receiver
    frame_n = 1'b0;
    wait_cyc(4);
    for (int i = 0; i < 10; i++) pulse_clk(1'b1);
    rst = 1'b1;
    wait_cyc(3);
    frame_n = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(3);
    check(upd_code === 16'h0, "R1 code cleared mid-frame", 32'(upd_code), 32'd0);
    exp_code = '0;
    frame_check(24'h00_BEEF, 24, 0, "R1 frame after reset");

    // R3: strobe width and code stability across the whole run
    check(hi_cycles == rises, "R3 strobe one cycle", 32'(hi_cycles), 32'(rises));
    check(stray == 0, "R3 code changes only with strobe", 32'(stray), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule